// File: doc/BRIEF.md
# Watchdog Timer With Early-Warning Flag

This block supervises firmware running on a small microcontroller subsystem. A free-running counter advances once per clock. When it reaches the configured timeout it issues a one-cycle reset request and starts again from zero. A fixed number of cycles before that moment it raises a warning flag. Firmware can react to the warning before the overflow happens.

Firmware keeps the counter from expiring by writing the key byte 0xFF to the restart register. The write must be a byte-sized access. An overflow also sets a sticky status bit. That bit sits in a separate always-powered reset domain, so it survives an ordinary core reset. After boot, firmware reads it to tell a watchdog recovery apart from a power fault.

The warning flag can be cleared in three ways: a firmware write, a falling edge on the wake input, or a restart. The status bit is cleared by a firmware write. It is also held clear for as long as the external reset pin is high.

Top module: `wdog_warn_top`

## Requirements
- R1: After core reset (`rst_n` low) and always-on reset (`aon_rst_n` low) are released, `reset_req`, `warn_flag` and `ovf_status` all read 0.
- R2: With no restart, `reset_req` rises at the sample taken TIMEOUT clock edges after the counter last started. It stays high for exactly one cycle. The counter then restarts from zero, so the next request follows TIMEOUT edges later.
- R3: `warn_flag` rises LEAD edges before `reset_req` rises, which is TIMEOUT-LEAD edges after the counter started. It stays set through the overflow.
- R4: A write with `wr_byte`=1 of data 8'hFF to address 0 restarts the counter. The next request then comes TIMEOUT edges after that write. The same write clears `warn_flag`.
- R5: A write to address 0 with any other data value, or with `wr_byte`=0, does not restart the counter and does not clear `warn_flag`.
- R6: A write to address 1 with data bit 0 equal to 0 clears `warn_flag`. A write to address 1 with data bit 0 equal to 1 leaves it unchanged.
- R7: A falling edge on `wake` (1 in one cycle, 0 in the next) clears `warn_flag`. A rising edge has no effect.
- R8: `ovf_status` becomes 1 one cycle after `reset_req`. It keeps that value through a core reset on `rst_n`.
- R9: A write to address 2 with data bit 0 equal to 0 clears `ovf_status`. A write with bit 0 equal to 1 has no effect on it.
- R10: While `rst_pin` is high, `ovf_status` is cleared and stays 0, even if an overflow occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Core reset, active low; clears the counter and the warning |
| aon_rst_n | input | 1 | Always-on domain reset, active low; clears the status bit only |
| rst_pin | input | 1 | External reset pin, active high; holds the status bit clear |
| wr_en | input | 1 | Register write strobe |
| wr_byte | input | 1 | The write is a byte-sized access |
| wr_addr | input | ADDR_W | Write address: 0 restart, 1 warning, 2 status |
| wr_data | input | 8 | Write data |
| wake | input | 1 | Wake signal, synchronous to clk |
| reset_req | output | 1 | One-cycle reset request on overflow |
| warn_flag | output | 1 | Early-warning flag |
| ovf_status | output | 1 | Sticky overflow status |

## Verification
The hardest state to reach is a status bit that was set by an overflow and then has to survive a core reset. The bench first lets the counter run out, then pulses `rst_n` alone while `aon_rst_n` stays high. It then reads the bit again before firmware clears it.

Proving that a write was ignored is also subtle. The bench places bad restart writes between a valid restart and the expected overflow. It then measures the edge count to the request against the valid restart. It also checks that the warning survives those writes.

// File: rtl/wdog_warn_pkg.sv
package wdog_warn_pkg;
    localparam int REG_KICK = 0;
    localparam int REG_WARN = 1;
    localparam int REG_STAT = 2;
    localparam logic [7:0] KICK_KEY = 8'hFF;

    typedef struct packed {
        logic kick;
        logic warn_clr;
        logic stat_clr;
    } wd_strobe_t;
endpackage

// File: rtl/wdog_regdec.sv
module wdog_regdec
    import wdog_warn_pkg::*;
#(
    parameter int ADDR_W = 2
) (
    input  logic              wr_en_i,
    input  logic              wr_byte_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [7:0]        wr_data_i,
    output wd_strobe_t        strobe_o
);
    localparam logic [ADDR_W-1:0] A_KICK = ADDR_W'(REG_KICK);
    localparam logic [ADDR_W-1:0] A_WARN = ADDR_W'(REG_WARN);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(REG_STAT);

    always_comb begin
        strobe_o          = '0;
        // restart only on a byte access carrying the key (R4, R5)
        strobe_o.kick     = wr_en_i && wr_byte_i && (wr_addr_i == A_KICK)
                            && (wr_data_i == KICK_KEY);
        strobe_o.warn_clr = wr_en_i && (wr_addr_i == A_WARN) && !wr_data_i[0];
        strobe_o.stat_clr = wr_en_i && (wr_addr_i == A_STAT) && !wr_data_i[0];
    end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
    import wdog_warn_pkg::*;
#(
    parameter int TIMEOUT = 200,
    parameter int LEAD    = 20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  wd_strobe_t strobe_i,
    input  logic       wake_i,
    output logic       req_o,
    output logic       warn_o
);
    localparam int CNT_W   = $clog2(TIMEOUT);
    localparam int WARN_AT = TIMEOUT - LEAD;
    localparam logic [CNT_W-1:0] TOP      = CNT_W'(TIMEOUT - 1);
    localparam logic [CNT_W-1:0] WARN_PRE = CNT_W'(WARN_AT - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             warn;
        logic             req;
        logic             wake;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic       wake_fall;

    always_comb begin
        st_d      = st_q;
        st_d.req  = 1'b0;
        st_d.wake = wake_i;
        wake_fall = st_q.wake && !wake_i;
        if (strobe_i.kick) begin
            st_d.cnt = '0;
        end else if (st_q.cnt == TOP) begin
            st_d.cnt = '0;
            st_d.req = 1'b1;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        if (!strobe_i.kick && st_q.cnt == WARN_PRE) begin
            st_d.warn = 1'b1;
        end
        if (strobe_i.kick || strobe_i.warn_clr || wake_fall) begin
            st_d.warn = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req_o  = st_q.req;
    assign warn_o = st_q.warn;

    assert_req_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.req |=> !st_q.req);
    assert_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == TOP && !strobe_i.kick) |=> (st_q.req && st_q.cnt == '0));
    assert_warn_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == WARN_PRE && !strobe_i.kick && !strobe_i.warn_clr && !wake_fall)
        |=> st_q.warn);
    assert_kick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_i.kick |=> (st_q.cnt == '0 && !st_q.warn && !st_q.req));
    assert_wake_clr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.wake && !wake_i) |=> !st_q.warn);
endmodule

// File: rtl/wdog_sticky.sv
module wdog_sticky
    import wdog_warn_pkg::*;
(
    input  logic       clk,
    input  logic       aon_rst_n,
    input  logic       rst_pin_i,
    input  logic       ovf_i,
    input  wd_strobe_t strobe_i,
    output logic       stat_o
);
    logic stat_d, stat_q;

    always_comb begin
        stat_d = stat_q;
        if (strobe_i.stat_clr) stat_d = 1'b0;
        if (ovf_i)             stat_d = 1'b1;
        if (rst_pin_i)         stat_d = 1'b0;
    end

    always_ff @(posedge clk or negedge aon_rst_n) begin
        if (!aon_rst_n) stat_q <= 1'b0;
        else            stat_q <= stat_d;
    end

    assign stat_o = stat_q;

    assert_stat_set_R8: assert property (@(posedge clk) disable iff (!aon_rst_n)
        (ovf_i && !rst_pin_i) |=> stat_q);
    assert_stat_pin_R10: assert property (@(posedge clk) disable iff (!aon_rst_n)
        rst_pin_i |=> !stat_q);
    assert_stat_fw_R9: assert property (@(posedge clk) disable iff (!aon_rst_n)
        (strobe_i.stat_clr && !ovf_i) |=> !stat_q);
endmodule

// File: rtl/wdog_warn_top.sv
module wdog_warn_top
    import wdog_warn_pkg::*;
#(
    parameter int TIMEOUT = 200,
    parameter int LEAD    = 20,
    parameter int ADDR_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              aon_rst_n,
    input  logic              rst_pin,
    input  logic              wr_en,
    input  logic              wr_byte,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              wake,
    output logic              reset_req,
    output logic              warn_flag,
    output logic              ovf_status
);
    wd_strobe_t strobe;

    initial begin
        assert (LEAD >= 1 && LEAD < TIMEOUT && TIMEOUT >= 2)
            else $error("wdog_warn_top: LEAD must lie in 1..TIMEOUT-1");
    end

    wdog_regdec #(.ADDR_W(ADDR_W)) u_dec (
        .wr_en_i  (wr_en),
        .wr_byte_i(wr_byte),
        .wr_addr_i(wr_addr),
        .wr_data_i(wr_data),
        .strobe_o (strobe)
    );

    wdog_counter #(.TIMEOUT(TIMEOUT), .LEAD(LEAD)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .strobe_i(strobe),
        .wake_i  (wake),
        .req_o   (reset_req),
        .warn_o  (warn_flag)
    );

    wdog_sticky u_stat (
        .clk      (clk),
        .aon_rst_n(aon_rst_n),
        .rst_pin_i(rst_pin),
        .ovf_i    (reset_req),
        .strobe_i (strobe),
        .stat_o   (ovf_status)
    );
endmodule

// File: tb/wdog_warn_top_tb.sv
module wdog_warn_top_tb;
    localparam int TO  = 40;
    localparam int LD  = 8;
    localparam int AW  = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0, aon_rst_n = 1'b0, rst_pin = 1'b0;
    logic wr_en = 1'b0, wr_byte = 1'b0, wake = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic reset_req, warn_flag, ovf_status;

    int total = 0;
    int bad = 0;
    int edges = 0;

    always #5 clk = ~clk;
    always @(posedge clk) edges <= edges + 1;

    wdog_warn_top #(.TIMEOUT(TO), .LEAD(LD), .ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .aon_rst_n(aon_rst_n), .rst_pin(rst_pin),
        .wr_en(wr_en), .wr_byte(wr_byte), .wr_addr(wr_addr), .wr_data(wr_data),
        .wake(wake), .reset_req(reset_req), .warn_flag(warn_flag),
        .ovf_status(ovf_status)
    );

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input int addr, input int data, input logic byte_acc);
        wr_en = 1'b1; wr_byte = byte_acc;
        wr_addr = AW'(addr); wr_data = 8'(data);
        @(negedge clk);
        wr_en = 1'b0; wr_byte = 1'b0;
    endtask

    task automatic kick(output int at);
        wr(0, 8'hFF, 1'b1);
        at = edges;
    endtask

    task automatic wait_req(output int at);
        while (!reset_req) @(negedge clk);
        at = edges;
    endtask

    task automatic wait_warn(output int at);
        while (!warn_flag) @(negedge clk);
        at = edges;
    endtask

    task automatic t_reset;
        check("R1 req", reset_req, 0);
        check("R1 warn", warn_flag, 0);
        check("R1 status", ovf_status, 0);
    endtask

    task automatic t_period;
        int t0, t1, t2;
        t0 = edges;
        wait_req(t1);
        check("R2 first request delay", t1 - t0, TO);
        @(negedge clk);
        check("R2 request width", reset_req, 0);
        wait_req(t2);
        check("R2 restart period", t2 - t1, TO);
        @(negedge clk);
    endtask

    task automatic t_warn_kick;
        int k, w, r;
        kick(k);
        check("R4 kick clears warn", warn_flag, 0);
        wait_warn(w);
        check("R3 warn delay", w - k, TO - LD);
        wait_req(r);
        check("R3 lead before request", r - w, LD);
        check("R3 warn held at overflow", warn_flag, 1);
        repeat (5) @(negedge clk);
        kick(k);
        repeat (TO - 5) @(negedge clk);
        kick(k);
        wait_req(r);
        check("R4 late kick restarts", r - k, TO);
        @(negedge clk);
    endtask

    task automatic t_bad_kick;
        int k, r;
        kick(k);
        repeat (TO - LD + 2) @(negedge clk);
        wr(0, 8'hFE, 1'b1);
        wr(0, 8'hFF, 1'b0);
        wr(0, 8'h7F, 1'b1);
        check("R5 warn kept after bad writes", warn_flag, 1);
        wait_req(r);
        check("R5 bad writes ignored", r - k, TO);
        @(negedge clk);
    endtask

    task automatic t_warn_fw;
        int k, w;
        kick(k);
        wait_warn(w);
        wr(1, 1, 1'b1);
        check("R6 bit0=1 keeps warn", warn_flag, 1);
        wr(1, 0, 1'b1);
        check("R6 bit0=0 clears warn", warn_flag, 0);
        kick(k);
    endtask

    task automatic t_wake;
        int k, w;
        kick(k);
        wait_warn(w);
        wake = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R7 rising wake ignored", warn_flag, 1);
        wake = 1'b0;
        @(negedge clk);
        check("R7 falling wake clears", warn_flag, 0);
        kick(k);
    endtask

    task automatic t_sticky;
        int r;
        kick(r);
        wait_req(r);
        @(negedge clk);
        check("R8 status set", ovf_status, 1);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8 status survives core reset", ovf_status, 1);
        check("R8 warn cleared by core reset", warn_flag, 0);
        wr(2, 1, 1'b1);
        check("R9 bit0=1 keeps status", ovf_status, 1);
        wr(2, 0, 1'b1);
        check("R9 bit0=0 clears status", ovf_status, 0);
    endtask

    task automatic t_pin;
        int r;
        kick(r);
        wait_req(r);
        @(negedge clk);
        check("R10 status set before pin", ovf_status, 1);
        rst_pin = 1'b1;
        @(negedge clk);
        check("R10 pin clears status", ovf_status, 0);
        wait_req(r);
        repeat (2) @(negedge clk);
        check("R10 held clear through overflow", ovf_status, 0);
        rst_pin = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #(10 * 150000);
        total++; bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1; aon_rst_n = 1'b1;
        t_reset();
        t_period();
        t_warn_kick();
        t_bad_kick();
        t_warn_fw();
        t_wake();
        t_sticky();
        t_pin();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule